// File: doc/BRIEF.md
# Password-Gated Paged Memory with One-Way Word Lock

This block holds 128 bytes of small storage, arranged as four pages of sixteen 16-bit words. It decides whether each access may go ahead. Each page has its own 32-bit key, and that key gates both reading and writing the page. A separate 16-bit chip-wide key grants the right to modify anything. Every word also has a protect flag. The flag starts at 1, meaning writable. Once it is cleared it cannot be raised again, and from then on the word refuses every write. A fixed 32-bit identity value can always be read. Storage is modelled as registers that are loaded with known contents at reset.

Commands arrive one at a time on a valid/ready stream. Each accepted command produces exactly one response on a second valid/ready stream. A response carries a status code and, for reads, a data value. Only one response can be outstanding. `cmd_ready` is high whenever the response slot is empty or is being emptied in the same cycle. So a stalled consumer, holding `rsp_ready` low, stops new commands from being accepted. While stalled, the pending response stays unchanged on its pins.

Top module: `pmem_lock_ctrl`

## Requirements
- R1: The memory holds 4 pages × 16 words × 16 bits. After reset, word w of page p holds MEM_SEED + 16·p + w, with MEM_SEED = 16'h5A00 by default. A read (op 2) of an unlocked page returns the word zero-extended, with status 0 (ok).
- R2: A page-key command (op 0) compares cmd_data against that page's key, PW_SEED + p, with PW_SEED = 32'hC0DE0000 by default. On a match it unlocks the page and returns status 0. On a mismatch it locks that page and returns status 3 (rejected).
- R3: A read (op 2) or a protect-flag read (op 5) of a locked page returns status 1 (locked) with data 0. Every response whose status is not 0 carries data 0.
- R4: A chip-key command (op 1) compares cmd_data[15:0] with CHIP_WPW (16'hBEEF by default). On a match it grants modify rights and returns status 0. On a mismatch it withdraws the grant and returns status 3.
- R5: A write (op 3, data in cmd_data[15:0]) changes memory only when the page is unlocked and the modify right is held. Otherwise it returns status 1 and the word keeps its value.
- R6: A write to a word whose protect flag is 0 returns status 2 (protected) and leaves the word unchanged, even when the page is unlocked and the modify right is held.
- R7: A burn (op 4) with the page unlocked and the modify right held clears the addressed protect flag and returns status 0. Without both conditions it returns status 1 and changes nothing. A cleared flag never returns to 1 before the next reset. A protect-flag read (op 5) returns the page's 16 flags in bits [15:0], with bit w belonging to word w.
- R8: An identity read (op 6) needs no key and returns CHIP_ID (32'h1234ABCD by default) with status 0.
- R9: Op 7 is reserved. It returns status 3 and changes no state.
- R10: A command is taken on a cycle where cmd_valid and cmd_ready are both high, and its response is valid on the next cycle. While rsp_valid is high and rsp_ready is low, cmd_ready is low and the response holds steady. A command offered during a stall is taken in the same cycle that the stalled response is taken.
- R11: Reset locks all pages, withdraws the modify right, empties the response slot, reloads the memory contents and sets every protect flag to 1.
- R12: Unlock state is kept separately for each page. A key command for one page never changes whether another page is unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 3 | Operation code (0..7, see requirements) |
| cmd_page | input | 2 | Page index |
| cmd_word | input | 4 | Word index within the page |
| cmd_data | input | 32 | Key or write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 32 | Read data, zero when the status is not ok |
| rsp_status | output | 2 | 0 ok, 1 locked, 2 protected, 3 rejected |

## Verification
The main access decision is tried with every combination of its three inputs: page locked or open, modify right absent or held, and word protect flag set or cleared. Each case separates a different status code. A read following each write shows whether memory actually changed. Wrong keys are aimed at one page while another page is open, which tells a per-page lock apart from a global one. A withdrawn chip grant on an open page separates the two gates from each other. A stalled response is held while a new command waits, which shows that the hand-off of the response and the acceptance of the next command happen in the same cycle.

// File: rtl/pmem_pkg.sv
package pmem_pkg;
  typedef enum logic [2:0] {
    OP_PAGE_KEY  = 3'd0,
    OP_CHIP_KEY  = 3'd1,
    OP_READ      = 3'd2,
    OP_WRITE     = 3'd3,
    OP_BURN      = 3'd4,
    OP_PROT_READ = 3'd5,
    OP_ID_READ   = 3'd6,
    OP_RSVD      = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    ST_OK        = 2'd0,
    ST_LOCKED    = 2'd1,
    ST_PROTECTED = 2'd2,
    ST_REJECT    = 2'd3
  } status_e;
endpackage

// File: rtl/pmem_auth.sv
module pmem_auth #(
  parameter int PAGES = 4,
  parameter int PW_W = 32,
  parameter int CPW_W = 16,
  parameter logic [PW_W-1:0] PW_SEED = 32'hC0DE_0000,
  parameter logic [CPW_W-1:0] CHIP_WPW = 16'hBEEF,
  localparam int PAGE_AW = $clog2(PAGES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               page_key_en,
  input  logic               chip_key_en,
  input  logic [PAGE_AW-1:0] page_sel,
  input  logic [PW_W-1:0]    key_data,
  output logic               page_key_ok,
  output logic               chip_key_ok,
  output logic [PAGES-1:0]   unlocked,
  output logic               wr_grant
);
  logic [PW_W-1:0] ref_key [PAGES];

  for (genvar p = 0; p < PAGES; p++) begin : g_page
    logic open_q;
    assign ref_key[p] = PW_SEED + PW_W'(p);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) open_q <= 1'b0;
      else if (page_key_en && page_sel == PAGE_AW'(p)) open_q <= page_key_ok;
    end
    assign unlocked[p] = open_q;
  end

  assign page_key_ok = (key_data == ref_key[page_sel]);
  assign chip_key_ok = (key_data[CPW_W-1:0] == CHIP_WPW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_grant <= 1'b0;
    else if (chip_key_en) wr_grant <= chip_key_ok;
  end
endmodule

// File: rtl/pmem_array.sv
module pmem_array #(
  parameter int PAGES = 4,
  parameter int WORDS = 16,
  parameter int WORD_W = 16,
  parameter logic [WORD_W-1:0] MEM_SEED = 16'h5A00,
  localparam int PAGE_AW = $clog2(PAGES),
  localparam int WORD_AW = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [PAGE_AW-1:0] page_sel,
  input  logic [WORD_AW-1:0] word_sel,
  input  logic [WORD_W-1:0]  wr_data,
  output logic [WORD_W-1:0]  rd_data
);
  logic [WORD_W-1:0] cell_q [PAGES][WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < PAGES; p++)
        for (int w = 0; w < WORDS; w++)
          cell_q[p][w] <= MEM_SEED + WORD_W'(p * WORDS + w);
    end else if (wr_en) begin
      cell_q[page_sel][word_sel] <= wr_data;
    end
  end

  assign rd_data = cell_q[page_sel][word_sel];
endmodule

// File: rtl/pmem_otp.sv
module pmem_otp #(
  parameter int PAGES = 4,
  parameter int WORDS = 16,
  localparam int PAGE_AW = $clog2(PAGES),
  localparam int WORD_AW = $clog2(WORDS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   burn_en,
  input  logic [PAGE_AW-1:0]     page_sel,
  input  logic [WORD_AW-1:0]     word_sel,
  output logic                   word_open,
  output logic [WORDS-1:0]       page_flags,
  output logic [PAGES*WORDS-1:0] all_flags
);
  for (genvar p = 0; p < PAGES; p++) begin : g_page
    logic [WORDS-1:0] flag_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '1;
      else if (burn_en && page_sel == PAGE_AW'(p)) flag_q[word_sel] <= 1'b0;
    end
    assign all_flags[p*WORDS +: WORDS] = flag_q;
  end

  assign page_flags = all_flags[page_sel*WORDS +: WORDS];
  assign word_open  = page_flags[word_sel];
endmodule

// File: rtl/pmem_lock_ctrl.sv
module pmem_lock_ctrl #(
  parameter int PAGES = 4,
  parameter int WORDS = 16,
  parameter int WORD_W = 16,
  parameter int PW_W = 32,
  parameter int CPW_W = 16,
  parameter int DATA_W = 32,
  parameter logic [WORD_W-1:0] MEM_SEED = 16'h5A00,
  parameter logic [PW_W-1:0] PW_SEED = 32'hC0DE_0000,
  parameter logic [CPW_W-1:0] CHIP_WPW = 16'hBEEF,
  parameter logic [DATA_W-1:0] CHIP_ID = 32'h1234_ABCD
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  output logic                      cmd_ready,
  input  logic [2:0]                cmd_op,
  input  logic [$clog2(PAGES)-1:0]  cmd_page,
  input  logic [$clog2(WORDS)-1:0]  cmd_word,
  input  logic [DATA_W-1:0]         cmd_data,
  output logic                      rsp_valid,
  input  logic                      rsp_ready,
  output logic [DATA_W-1:0]         rsp_data,
  output logic [1:0]                rsp_status
);
  import pmem_pkg::*;

  localparam int BITS = PAGES * WORDS;

  logic accept;
  op_e  op;
  logic page_key_ok, chip_key_ok, wr_grant;
  logic [PAGES-1:0] unlocked;
  logic page_open, may_modify;
  logic arr_we, burn_en, pk_en, ck_en;
  logic [WORD_W-1:0] arr_rdata;
  logic word_open;
  logic [WORDS-1:0] page_flags;
  logic [BITS-1:0] all_flags;
  status_e nx_status;
  logic [DATA_W-1:0] nx_data;
  logic rsp_valid_q;
  status_e rsp_status_q;
  logic [DATA_W-1:0] rsp_data_q;

  assign cmd_ready  = !rsp_valid_q || rsp_ready;
  assign accept     = cmd_valid && cmd_ready;
  assign op         = op_e'(cmd_op);
  assign page_open  = unlocked[cmd_page];
  assign may_modify = page_open && wr_grant;

  pmem_auth #(
    .PAGES(PAGES), .PW_W(PW_W), .CPW_W(CPW_W),
    .PW_SEED(PW_SEED), .CHIP_WPW(CHIP_WPW)
  ) u_auth (
    .clk(clk), .rst_n(rst_n),
    .page_key_en(pk_en), .chip_key_en(ck_en),
    .page_sel(cmd_page), .key_data(cmd_data[PW_W-1:0]),
    .page_key_ok(page_key_ok), .chip_key_ok(chip_key_ok),
    .unlocked(unlocked), .wr_grant(wr_grant)
  );

  pmem_array #(
    .PAGES(PAGES), .WORDS(WORDS), .WORD_W(WORD_W), .MEM_SEED(MEM_SEED)
  ) u_array (
    .clk(clk), .rst_n(rst_n), .wr_en(arr_we),
    .page_sel(cmd_page), .word_sel(cmd_word),
    .wr_data(cmd_data[WORD_W-1:0]), .rd_data(arr_rdata)
  );

  pmem_otp #(
    .PAGES(PAGES), .WORDS(WORDS)
  ) u_otp (
    .clk(clk), .rst_n(rst_n), .burn_en(burn_en),
    .page_sel(cmd_page), .word_sel(cmd_word),
    .word_open(word_open), .page_flags(page_flags), .all_flags(all_flags)
  );

  // Decision for the command on the input; side effects gated by accept.
  always_comb begin
    nx_status = ST_REJECT;
    nx_data   = '0;
    arr_we    = 1'b0;
    burn_en   = 1'b0;
    pk_en     = 1'b0;
    ck_en     = 1'b0;
    unique case (op)
      OP_PAGE_KEY: begin
        pk_en     = accept;
        nx_status = page_key_ok ? ST_OK : ST_REJECT;
      end
      OP_CHIP_KEY: begin
        ck_en     = accept;
        nx_status = chip_key_ok ? ST_OK : ST_REJECT;
      end
      OP_READ: begin
        if (page_open) begin
          nx_status = ST_OK;
          nx_data   = DATA_W'(arr_rdata);
        end else begin
          nx_status = ST_LOCKED;
        end
      end
      OP_WRITE: begin
        if (!may_modify)      nx_status = ST_LOCKED;
        else if (!word_open)  nx_status = ST_PROTECTED;
        else begin
          nx_status = ST_OK;
          arr_we    = accept;
        end
      end
      OP_BURN: begin
        if (may_modify) begin
          nx_status = ST_OK;
          burn_en   = accept;
        end else begin
          nx_status = ST_LOCKED;
        end
      end
      OP_PROT_READ: begin
        if (page_open) begin
          nx_status = ST_OK;
          nx_data   = DATA_W'(page_flags);
        end else begin
          nx_status = ST_LOCKED;
        end
      end
      OP_ID_READ: begin
        nx_status = ST_OK;
        nx_data   = CHIP_ID;
      end
      default: nx_status = ST_REJECT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q  <= 1'b0;
      rsp_status_q <= ST_OK;
      rsp_data_q   <= '0;
    end else if (accept) begin
      rsp_valid_q  <= 1'b1;
      rsp_status_q <= nx_status;
      rsp_data_q   <= nx_data;
    end else if (rsp_ready) begin
      rsp_valid_q  <= 1'b0;
    end
  end

  assign rsp_valid  = rsp_valid_q;
  assign rsp_status = rsp_status_q;
  assign rsp_data   = rsp_data_q;
endmodule

// File: rtl/pmem_lock_sva.sv
module pmem_lock_sva #(
  parameter int DATA_W = 32,
  parameter int BITS = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic [1:0]        rsp_status,
  input logic              mem_we,
  input logic              word_open,
  input logic              page_open,
  input logic              grant,
  input logic [BITS-1:0]   flags
);
  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_status));

  // R10
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> rsp_valid);

  // R3
  deny_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_status != 2'd0 |-> rsp_data == '0);

  // R5
  we_auth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> page_open && grant);

  // R6
  we_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> word_open);

  // R7
  flag_oneway_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & ~$past(flags)) == '0);
endmodule

bind pmem_lock_ctrl pmem_lock_sva #(.DATA_W(DATA_W), .BITS(PAGES*WORDS)) u_sva (
  .clk(clk), .rst_n(rst_n),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_data(rsp_data), .rsp_status(rsp_status),
  .mem_we(arr_we), .word_open(word_open), .page_open(page_open),
  .grant(wr_grant), .flags(all_flags)
);

// File: tb/pmem_lock_ctrl_tb_top.sv
module pmem_lock_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [1:0] cmd_page = '0;
  logic [3:0] cmd_word = '0;
  logic [31:0] cmd_data = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic [1:0] rsp_status;

  int nchk = 0;
  int nerr = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  pmem_lock_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_page(cmd_page), .cmd_word(cmd_word), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_status(rsp_status)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      nerr = nerr + 1;
      $display("FAIL watchdog actual %0d cycles expected completion", cyc);
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk = nchk + 1;
    if (act !== exp) begin
      nerr = nerr + 1;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [2:0] op, input logic [1:0] pg, input logic [3:0] wd,
                        input logic [31:0] dat, output logic vld, output logic [1:0] st,
                        output logic [31:0] d);
    @(negedge clk);
    cmd_op = op; cmd_page = pg; cmd_word = wd; cmd_data = dat; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    vld = rsp_valid; st = rsp_status; d = rsp_data;
  endtask

  // op(3) page(2) word(4) data(32) status(2) expected data(32)
  localparam int NV = 27;
  localparam logic [74:0] VEC [NV] = '{
    {3'd2, 2'd1, 4'd3, 32'h0,          2'd1, 32'h0},         // R3 locked read
    {3'd0, 2'd1, 4'd0, 32'hC0DE0001,   2'd0, 32'h0},         // R2 unlock page 1
    {3'd2, 2'd1, 4'd3, 32'h0,          2'd0, 32'h00005A13},  // R1 reset contents
    {3'd3, 2'd1, 4'd3, 32'h1111,       2'd1, 32'h0},         // R5 no grant
    {3'd1, 2'd0, 4'd0, 32'h0000BEEF,   2'd0, 32'h0},         // R4 grant
    {3'd3, 2'd1, 4'd3, 32'h1111,       2'd0, 32'h0},         // R5 write ok
    {3'd2, 2'd1, 4'd3, 32'h0,          2'd0, 32'h00001111},  // R5 readback
    {3'd4, 2'd1, 4'd3, 32'h0,          2'd0, 32'h0},         // R7 burn
    {3'd5, 2'd1, 4'd0, 32'h0,          2'd0, 32'h0000FFF7},  // R7 flags
    {3'd3, 2'd1, 4'd3, 32'h2222,       2'd2, 32'h0},         // R6 protected
    {3'd2, 2'd1, 4'd3, 32'h0,          2'd0, 32'h00001111},  // R6 unchanged
    {3'd3, 2'd2, 4'd0, 32'h3333,       2'd1, 32'h0},         // R5 page 2 locked
    {3'd0, 2'd2, 4'd0, 32'hC0DE0009,   2'd3, 32'h0},         // R2 wrong key
    {3'd2, 2'd1, 4'd3, 32'h0,          2'd0, 32'h00001111},  // R12 page 1 still open
    {3'd6, 2'd0, 4'd0, 32'h0,          2'd0, 32'h1234ABCD},  // R8 identity
    {3'd7, 2'd1, 4'd3, 32'h0,          2'd3, 32'h0},         // R9 reserved
    {3'd0, 2'd1, 4'd0, 32'hC0DE0002,   2'd3, 32'h0},         // R2 wrong key relocks
    {3'd2, 2'd1, 4'd3, 32'h0,          2'd1, 32'h0},         // R2 page 1 locked
    {3'd1, 2'd0, 4'd0, 32'h00000000,   2'd3, 32'h0},         // R4 grant withdrawn
    {3'd0, 2'd1, 4'd0, 32'hC0DE0001,   2'd0, 32'h0},         // R2 reopen
    {3'd3, 2'd1, 4'd4, 32'h4444,       2'd1, 32'h0},         // R4 write needs grant
    {3'd2, 2'd1, 4'd4, 32'h0,          2'd0, 32'h00005A14},  // R5 unchanged
    {3'd0, 2'd3, 4'd0, 32'hC0DE0003,   2'd0, 32'h0},         // R2 page 3
    {3'd2, 2'd3, 4'd15, 32'h0,         2'd0, 32'h00005A3F},  // R1 last word
    {3'd2, 2'd0, 4'd0, 32'h0,          2'd1, 32'h0},         // R12 page 0 locked
    {3'd4, 2'd1, 4'd4, 32'h0,          2'd1, 32'h0},         // R7 burn needs grant
    {3'd5, 2'd1, 4'd0, 32'h0,          2'd0, 32'h0000FFF7}   // R7 flags unchanged
  };
  localparam int VREQ [NV] = '{3,2,1,5,4,5,5,7,7,6,6,5,2,12,8,9,2,2,4,2,4,5,2,1,12,7,7};

  initial begin
    logic v;
    logic [1:0] st;
    logic [31:0] d;
    string tag;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 cmd_ready after reset", {31'b0, cmd_ready}, 32'd1);
    chk("R11 rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      do_cmd(VEC[i][74:72], VEC[i][71:70], VEC[i][69:66], VEC[i][65:34], v, st, d);
      tag = $sformatf("R%0d vec%0d", VREQ[i], i);
      chk({tag, " valid"}, {31'b0, v}, 32'd1);
      chk({tag, " status"}, {30'b0, st}, {30'b0, VEC[i][33:32]});
      chk({tag, " data"}, d, VEC[i][31:0]);
    end

    // R10 back-pressure: stall a response, offer a second command meanwhile
    @(negedge clk);
    rsp_ready = 1'b0;
    cmd_op = 3'd6; cmd_page = 2'd0; cmd_word = 4'd0; cmd_data = '0; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_op = 3'd2; cmd_page = 2'd0;
    chk("R10 stalled rsp_valid", {31'b0, rsp_valid}, 32'd1);
    chk("R10 cmd_ready low in stall", {31'b0, cmd_ready}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R10 held data", rsp_data, 32'h1234ABCD);
    chk("R10 held status", {30'b0, rsp_status}, 32'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R10 next rsp valid", {31'b0, rsp_valid}, 32'd1);
    chk("R10 next rsp status", {30'b0, rsp_status}, 32'd1);
    @(negedge clk);
    chk("R10 slot empties", {31'b0, rsp_valid}, 32'd0);

    // R11 mid-run reset: locks, reloads memory and flags
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    do_cmd(3'd2, 2'd1, 4'd3, 32'h0, v, st, d);
    chk("R11 relocked status", {30'b0, st}, 32'd1);
    do_cmd(3'd0, 2'd1, 4'd0, 32'hC0DE0001, v, st, d);
    do_cmd(3'd2, 2'd1, 4'd3, 32'h0, v, st, d);
    chk("R11 reloaded word", d, 32'h00005A13);
    do_cmd(3'd5, 2'd1, 4'd0, 32'h0, v, st, d);
    chk("R11 reloaded flags", d, 32'h0000FFFF);
    do_cmd(3'd3, 2'd1, 4'd3, 32'h7777, v, st, d);
    chk("R11 grant withdrawn", {30'b0, st}, 32'd1);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule